// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable counter of an uncore performance monitor. Every clock it receives the activity of three event sources: four cross-core snoop response pulses, a small number of last-level cache lookup ports, and the current level of a memory request tracker. A control register picks one event with an event code and a unit mask. The block works out how many selected events happened in that cycle and passes that count through three optional qualifiers: a count threshold, an inversion of the threshold test, and rising-edge detection. The result advances a wide counter.

Software reads and writes both the control register and the counter through a plain register port. Each register has a write strobe, a write-data bus and a read-data bus that always shows the current contents. A written value is visible on the read bus in the cycle after the strobe. Counting in a given cycle uses the control value held at the start of that cycle.

Top module: `qual_evt_counter`

## Requirements
- R1: The control register holds the event code in bits [7:0], the unit mask in [15:8], the threshold in [23:16], edge enable in bit 24, invert in bit 25 and counter enable in bit 26. With event code 0x22 and a zero threshold, the counter adds, in one cycle, the number of set bits of `snp_rsp & mask[3:0]`. Bit 0 is miss, bit 1 is invalidate, bit 2 is hit-clean and bit 3 is hit-modified.
- R2: With event code 0x34, each valid lookup port counts one when both of its mask bits are set. The line-state bit is mask bit 0 for M (state code 0), bit 1 for E (code 1), bit 2 for S (code 2) and bit 3 for I (code 3). The request-type bit is mask bit 4 for read (type code 0), bit 5 for write (code 1) and bit 6 for external snoop (code 2). Mask bit 7 matches every type, including code 3.
- R3: A lookup mask with request-type bits set but no line-state bit counts nothing.
- R4: Event code 0x80 with mask exactly 0x01 adds the value of `occ_level` each cycle. Any other mask with that code counts nothing.
- R5: With a nonzero threshold and invert clear, the counter adds one in a cycle whose selected count is greater than or equal to the threshold, and nothing otherwise.
- R6: With a nonzero threshold and invert set, the counter adds one in a cycle whose count is below the threshold. With a zero threshold the invert bit has no effect.
- R7: With edge enable set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous counted cycle. With a zero threshold the condition is "count is nonzero".
- R8: Writing the control register clears the remembered condition, so the first cycle after the write can register an edge.
- R9: A counter write loads `cnt_wdata` and takes priority over any increment in the same cycle. The counter and the control register are readable on their read buses.
- R10: The counter is CNT_W (48) bits wide and wraps modulo 2^CNT_W.
- R11: With the enable bit clear, the counter holds its value. Event codes other than 0x22, 0x34 and 0x80 count nothing.
- R12: Reset clears the control register, the counter and the remembered edge condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register contents |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| cnt_rdata | output | CNT_W | Counter value |
| snp_rsp | input | 4 | Snoop response pulses: miss, invalidate, hit-clean, hit-modified |
| lk_vld | input | NLK | Lookup valid per port |
| lk_state | input | 2*NLK | Line state code per port |
| lk_req | input | 2*NLK | Request type code per port |
| occ_level | input | OCC_W | Outstanding memory request level |

## Verification
The bench builds the block with the default parameters: a 48-bit counter, two lookup ports and a 4-bit occupancy level. With two lookup ports, a single cycle can produce 0, 1 or 2 lookups. That lets a threshold of 2 be hit, missed, and inverted using lookup traffic alone. The 4-bit occupancy input makes a weighted step of 9 possible, which separates weighted counting from counting by one. Keeping the full 48-bit width means the wrap case is reached by loading all ones and adding a multi-event step.

// File: rtl/qual_evt_counter.sv
module qual_evt_counter #(
  parameter int CNT_W = 48,
  parameter int NLK   = 2,
  parameter int OCC_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 cnt_we,
  input  logic [CNT_W-1:0]     cnt_wdata,
  output logic [CNT_W-1:0]     cnt_rdata,
  input  logic [3:0]           snp_rsp,
  input  logic [NLK-1:0]       lk_vld,
  input  logic [2*NLK-1:0]     lk_state,
  input  logic [2*NLK-1:0]     lk_req,
  input  logic [OCC_W-1:0]     occ_level
);

  localparam int LKC_W = $clog2(NLK + 5);
  localparam int CW    = (OCC_W > LKC_W) ? OCC_W + 1 : LKC_W + 1;
  localparam int CMP_W = (CW > 8) ? CW : 8;

  localparam logic [7:0] EV_SNOOP  = 8'h22;
  localparam logic [7:0] EV_LOOKUP = 8'h34;
  localparam logic [7:0] EV_OCC    = 8'h80;

  logic [26:0]      cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prev_q;

  logic [7:0] ev_code, ev_mask, thr;
  logic       edge_en, inv_en, cnt_en;

  assign ev_code = cfg_q[7:0];
  assign ev_mask = cfg_q[15:8];
  assign thr     = cfg_q[23:16];
  assign edge_en = cfg_q[24];
  assign inv_en  = cfg_q[25];
  assign cnt_en  = cfg_q[26];

  assign cfg_rdata = {5'b0, cfg_q};
  assign cnt_rdata = cnt_q;

  logic [NLK-1:0] lk_hit;

  for (genvar i = 0; i < NLK; i++) begin : g_lk
    logic [1:0] st, rq;
    assign st = lk_state[2*i +: 2];
    assign rq = lk_req[2*i +: 2];
    assign lk_hit[i] = lk_vld[i] && ev_mask[st] &&
                       (ev_mask[3'd4 + {1'b0, rq}] || ev_mask[7]);
  end

  logic [CW-1:0] snp_cnt, lk_cnt, sel_cnt;

  always_comb begin
    snp_cnt = '0;
    for (int k = 0; k < 4; k++)
      snp_cnt = snp_cnt + CW'(snp_rsp[k] & ev_mask[k]);
    lk_cnt = '0;
    for (int k = 0; k < NLK; k++)
      lk_cnt = lk_cnt + CW'(lk_hit[k]);
  end

  always_comb begin
    case (ev_code)
      EV_SNOOP:  sel_cnt = snp_cnt;
      EV_LOOKUP: sel_cnt = lk_cnt;
      EV_OCC:    sel_cnt = (ev_mask == 8'h01) ? CW'(occ_level) : '0;
      default:   sel_cnt = '0;
    endcase
  end

  logic cond, thr_zero;
  logic [CNT_W-1:0] inc;

  assign thr_zero = (thr == 8'd0);

  always_comb begin
    if (thr_zero)
      cond = (sel_cnt != '0);
    else if (inv_en)
      cond = CMP_W'(sel_cnt) < CMP_W'(thr);
    else
      cond = CMP_W'(sel_cnt) >= CMP_W'(thr);
  end

  always_comb begin
    if (edge_en)
      inc = CNT_W'(cond & ~prev_q);
    else if (thr_zero)
      inc = CNT_W'(sel_cnt);
    else
      inc = CNT_W'(cond);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      if (cfg_we)
        cfg_q <= cfg_wdata[26:0];

      if (cfg_we)
        prev_q <= 1'b0;
      else if (cnt_en)
        prev_q <= cond;

      if (cnt_we)
        cnt_q <= cnt_wdata;
      else if (cnt_en)
        cnt_q <= cnt_q + inc;
    end
  end

endmodule

// File: rtl/qual_evt_counter_chk.sv
module qual_evt_counter_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_rdata
);

  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] step;

  always_ff @(posedge clk) last_cnt <= cnt_rdata;
  assign step = cnt_rdata - last_cnt;

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_rdata == $past(cnt_wdata));

  p_cfg_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[26:0] == $past(cfg_wdata[26:0]));

  p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && !cfg_rdata[26]) |=> $stable(cnt_rdata));

  p_edge_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && cfg_rdata[26] && cfg_rdata[24]) |=> step <= CNT_W'(1));

  p_thr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && cfg_rdata[26] && cfg_rdata[23:16] != 8'd0) |=> step <= CNT_W'(1));

  p_reset_r12: assert property (@(posedge clk)
    !rst_n |=> (cnt_rdata == '0 && cfg_rdata == 32'd0));

endmodule

bind qual_evt_counter qual_evt_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .cnt_rdata(cnt_rdata)
);

// File: tb/sim_qual_evt_counter.sv
module sim_qual_evt_counter;
  localparam int CNT_W = 48;
  localparam int NLK   = 2;
  localparam int OCC_W = 4;
  localparam int NV    = 19;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             cfg_we, cnt_we;
  logic [31:0]      cfg_wdata, cfg_rdata;
  logic [CNT_W-1:0] cnt_wdata, cnt_rdata;
  logic [3:0]       snp_rsp;
  logic [NLK-1:0]   lk_vld;
  logic [2*NLK-1:0] lk_state, lk_req;
  logic [OCC_W-1:0] occ_level;

  qual_evt_counter #(.CNT_W(CNT_W), .NLK(NLK), .OCC_W(OCC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cnt_rdata(cnt_rdata), .snp_rsp(snp_rsp), .lk_vld(lk_vld),
    .lk_state(lk_state), .lk_req(lk_req), .occ_level(occ_level)
  );

  // {cfg, snp, vld, state, req, occ, expected step}
  localparam logic [57:0] VECS [NV] = '{
    {32'h0400_0F22, 4'b1011, 2'b00, 4'b0000, 4'b0000, 4'd0, 8'd3},
    {32'h0400_0522, 4'b1111, 2'b00, 4'b0000, 4'b0000, 4'd0, 8'd2},
    {32'h0403_0F22, 4'b1011, 2'b00, 4'b0000, 4'b0000, 4'd0, 8'd1},
    {32'h0404_0F22, 4'b1011, 2'b00, 4'b0000, 4'b0000, 4'd0, 8'd0},
    {32'h0604_0F22, 4'b1011, 2'b00, 4'b0000, 4'b0000, 4'd0, 8'd1},
    {32'h0600_0F22, 4'b0011, 2'b00, 4'b0000, 4'b0000, 4'd0, 8'd2},
    {32'h0400_1134, 4'b0000, 2'b11, 4'b0000, 4'b0100, 4'd0, 8'd1},
    {32'h0400_8134, 4'b0000, 2'b11, 4'b0000, 4'b0100, 4'd0, 8'd2},
    {32'h0400_F034, 4'b0000, 2'b11, 4'b0000, 4'b0100, 4'd0, 8'd0},
    {32'h0400_1634, 4'b0000, 2'b11, 4'b1001, 4'b0000, 4'd0, 8'd2},
    {32'h0400_1834, 4'b0000, 2'b11, 4'b1101, 4'b0000, 4'd0, 8'd1},
    {32'h0400_1634, 4'b0000, 2'b01, 4'b0101, 4'b0000, 4'd0, 8'd1},
    {32'h0400_0180, 4'b0000, 2'b00, 4'b0000, 4'b0000, 4'd9, 8'd9},
    {32'h0405_0180, 4'b0000, 2'b00, 4'b0000, 4'b0000, 4'd9, 8'd1},
    {32'h0400_0280, 4'b0000, 2'b00, 4'b0000, 4'b0000, 4'd9, 8'd0},
    {32'h0000_0F22, 4'b1111, 2'b00, 4'b0000, 4'b0000, 4'd0, 8'd0},
    {32'h0400_0F55, 4'b1111, 2'b00, 4'b0000, 4'b0000, 4'd0, 8'd0},
    {32'h0402_1634, 4'b0000, 2'b11, 4'b1001, 4'b0000, 4'd0, 8'd1},
    {32'h0602_1634, 4'b0000, 2'b01, 4'b0101, 4'b0000, 4'd0, 8'd1}
  };

  function automatic string vec_req(int i);
    case (i)
      0, 1:     return "R1";
      2, 3:     return "R5";
      4, 5, 18: return "R6";
      6, 7, 9, 10, 11: return "R2";
      8:        return "R3";
      12, 13, 14: return "R4";
      17:       return "R5";
      default:  return "R11";
    endcase
  endfunction

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    snp_rsp = '0; lk_vld = '0; lk_state = '0; lk_req = '0; occ_level = '0;
  endtask

  task automatic setup(logic [31:0] cfg, logic [CNT_W-1:0] start);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = cfg; cnt_we = 1'b1; cnt_wdata = start;
    idle_inputs();
    @(negedge clk);
    cfg_we = 1'b0; cnt_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cnt_we = 1'b0; cfg_wdata = '0; cnt_wdata = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R12", cnt_rdata, '0);
    check("R12", CNT_W'(cfg_rdata), '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      setup(VECS[i][57:26], '0);
      snp_rsp = VECS[i][25:22]; lk_vld = VECS[i][21:20];
      lk_state = VECS[i][19:16]; lk_req = VECS[i][15:12]; occ_level = VECS[i][11:8];
      @(negedge clk);
      idle_inputs();
      check(vec_req(i), cnt_rdata, CNT_W'(VECS[i][7:0]));
    end

    // R9: load and read back, then load wins over an increment
    setup(32'h0400_0F22, CNT_W'(48'h1234_5678_9ABC));
    check("R9", cnt_rdata, CNT_W'(48'h1234_5678_9ABC));
    check("R1", CNT_W'(cfg_rdata), CNT_W'(32'h0400_0F22));
    snp_rsp = 4'b1111; cnt_we = 1'b1; cnt_wdata = CNT_W'(100);
    @(negedge clk);
    cnt_we = 1'b0; idle_inputs();
    check("R9", cnt_rdata, CNT_W'(100));

    // R10: wrap
    setup(32'h0400_0F22, '1);
    snp_rsp = 4'b0111;
    @(negedge clk);
    idle_inputs();
    check("R10", cnt_rdata, CNT_W'(2));

    // R7: edge counting with zero threshold
    setup(32'h0500_0F22, '0);
    snp_rsp = 4'b0001;
    repeat (5) @(negedge clk);
    check("R7", cnt_rdata, CNT_W'(1));
    snp_rsp = 4'b0000;
    @(negedge clk);
    snp_rsp = 4'b0011;
    repeat (3) @(negedge clk);
    check("R7", cnt_rdata, CNT_W'(2));

    // R8: control write while condition stays true re-arms the edge
    cfg_we = 1'b1; cfg_wdata = 32'h0500_0F22;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R8", cnt_rdata, CNT_W'(2));
    @(negedge clk);
    check("R8", cnt_rdata, CNT_W'(3));
    repeat (2) @(negedge clk);
    check("R7", cnt_rdata, CNT_W'(3));
    idle_inputs();

    // R11: disabled counter ignores a long burst
    setup(32'h0000_0F22, CNT_W'(7));
    snp_rsp = 4'b1111;
    repeat (4) @(negedge clk);
    idle_inputs();
    check("R11", cnt_rdata, CNT_W'(7));

    // R12: reset after activity
    setup(32'h0400_0F22, CNT_W'(55));
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R12", cnt_rdata, '0);
    check("R12", CNT_W'(cfg_rdata), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule